// File: doc/BRIEF.md
# Nibble-Split Crosswise 8x8 Multiplier

This block multiplies two unsigned 8-bit operands into a 16-bit product. Each operand is broken into a high nibble and a low nibble. The four nibble pairings go to four identical 4x4 cores. Each core works column by column, vertically and crosswise. For each output column it adds every bit-product whose indices sum to that column, plus the carry from the column below. It finishes its 8-bit result in one pass and never adds shifted partial-product rows.

Exactly three adders merge the four core results at their overlapping offsets:

- The first adder sums the two cross products.
- The second adder adds the upper nibble of the low-by-low product to that sum.
- The third adder places the upper part of that result onto the high-by-high product, at bit offset 8.

The low four product bits come straight from the low-by-low core. A parameter selects an optional output register, which is on by default and has a synchronous active-high reset.

Top module: `vedic_mult8`

## Requirements
- R1: `product` equals the unsigned value of `op_a` times `op_b` for every one of the 65536 operand pairs.
- R2: When both operands are below 16, `product` equals the low-by-low nibble product, and `product[15:8]` is zero.
- R3: When both operands have zero low nibbles, `product[7:0]` is zero and `product[15:8]` equals the product of the two high nibbles.
- R4: `product[3:0]` always equals bits [3:0] of `op_a[3:0]` times `op_b[3:0]`, whatever the high nibbles hold.
- R5: A zero on either operand gives a zero product.
- R6: When one operand is 1, `product` equals the other operand, zero-extended to 16 bits.
- R7: The largest operands, 255 times 255, give 16'hFE01, with no wrap.
- R8: With `REG_OUT=1`, which is the default, `product` appears one rising clock edge after the operands. While `rst` is high at a rising edge, `product` is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| product | output | 16 | Unsigned product, registered when `REG_OUT=1` |

## Verification
On every cycle, the assertions check the full product against the operands seen one edge earlier. They also check the low nibble that passes straight through, the zero and identity operand cases, and the clearing by reset. Exhaustiveness is something only the bench's sweep can show: it tries every pair, including the 255 times 255 corner and the nibble-aligned subsets. The bench also shows the one-edge latency directly, by changing the operands and reading the output before the next edge.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 2 * NIB_W;
    localparam int CORE_W = 2 * NIB_W;
    localparam int PROD_W = 2 * OP_W;
    localparam int NCORES = 4;

    typedef struct packed {
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
    } nib_pair_t;

    // Core results: hh = aH*bH, hl = aH*bL, lh = aL*bH, ll = aL*bL
    typedef struct packed {
        logic [CORE_W-1:0] hh;
        logic [CORE_W-1:0] hl;
        logic [CORE_W-1:0] lh;
        logic [CORE_W-1:0] ll;
    } core_set_t;

    function automatic nib_pair_t split_op(input logic [OP_W-1:0] v);
        nib_pair_t r;
        r.hi = v[OP_W-1:NIB_W];
        r.lo = v[NIB_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/vm_crosswise_core.sv
module vm_crosswise_core
    import vmul_pkg::*;
(
    input  logic [NIB_W-1:0]  x,
    input  logic [NIB_W-1:0]  y,
    output logic [CORE_W-1:0] p
);
    localparam int NCOL = 2 * NIB_W - 1;
    localparam int CW   = $clog2(2 * NIB_W) + 2;

    logic [CW-1:0] col;
    logic [CW-1:0] carry;

    always_comb begin
        carry = '0;
        col   = '0;
        p     = '0;
        for (int k = 0; k < NCOL; k++) begin
            col = carry;
            for (int i = 0; i < NIB_W; i++) begin
                for (int j = 0; j < NIB_W; j++) begin
                    if (i + j == k) begin
                        col = col + CW'(x[i] & y[j]);
                    end
                end
            end
            p[k]  = col[0];
            carry = col >> 1;
        end
        p[CORE_W-1] = carry[0];
    end
endmodule

// File: rtl/vm_adder.sv
module vm_adder #(
    parameter int AW = 8,
    parameter int BW = 8,
    parameter int OW = 9
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [OW-1:0] s
);
    assign s = OW'(a) + OW'(b);
endmodule

// File: rtl/vm_overlap_merge.sv
module vm_overlap_merge
    import vmul_pkg::*;
(
    input  core_set_t         cores,
    output logic [PROD_W-1:0] prod
);
    localparam int S1_W = CORE_W + 1;
    localparam int S2_W = CORE_W + 2;
    localparam int UP_W = S2_W - NIB_W;

    logic [S1_W-1:0] cross_sum;
    logic [S2_W-1:0] mid_sum;
    logic [CORE_W-1:0] top_sum;

    // Adder 1: two cross products
    vm_adder #(.AW(CORE_W), .BW(CORE_W), .OW(S1_W)) u_add_cross (
        .a(cores.hl), .b(cores.lh), .s(cross_sum)
    );

    // Adder 2: add the upper nibble of the low-by-low product
    vm_adder #(.AW(S1_W), .BW(CORE_W - NIB_W), .OW(S2_W)) u_add_mid (
        .a(cross_sum), .b(cores.ll[CORE_W-1:NIB_W]), .s(mid_sum)
    );

    // Adder 3: upper part of the middle sum onto the high-by-high product
    vm_adder #(.AW(CORE_W), .BW(UP_W), .OW(CORE_W)) u_add_top (
        .a(cores.hh), .b(mid_sum[S2_W-1:NIB_W]), .s(top_sum)
    );

    assign prod = {top_sum, mid_sum[NIB_W-1:0], cores.ll[NIB_W-1:0]};
endmodule

// File: rtl/vmul_checker.sv
module vmul_checker
    import vmul_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic [PROD_W-1:0] product
);
    logic [CORE_W-1:0] ll_ref;
    logic [PROD_W-1:0] full_ref;
    assign ll_ref   = CORE_W'(op_a[NIB_W-1:0]) * CORE_W'(op_b[NIB_W-1:0]);
    assign full_ref = PROD_W'(op_a) * PROD_W'(op_b);

    generate
        if (REG_OUT) begin : g_reg
            AST_FULL_PRODUCT: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> product == $past(full_ref)); // R1
            AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> product[NIB_W-1:0] == $past(ll_ref[NIB_W-1:0])); // R4
            AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
                (op_a == '0 || op_b == '0) |=> product == '0); // R5
            AST_IDENTITY: assert property (@(posedge clk) disable iff (rst)
                (op_b == OP_W'(1)) |=> product == PROD_W'($past(op_a))); // R6
            AST_RESET_CLEARS: assert property (@(posedge clk)
                rst |=> product == '0); // R8
        end else begin : g_comb
            AST_FULL_PRODUCT: assert property (@(posedge clk) disable iff (rst)
                product == full_ref); // R1
            AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (rst)
                product[NIB_W-1:0] == ll_ref[NIB_W-1:0]); // R4
            AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
                (op_a == '0 || op_b == '0) |-> product == '0); // R5
            AST_IDENTITY: assert property (@(posedge clk) disable iff (rst)
                (op_b == OP_W'(1)) |-> product == PROD_W'(op_a)); // R6
        end
    endgenerate
endmodule

bind vedic_mult8 vmul_checker #(.REG_OUT(REG_OUT)) u_vmul_checker (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .product(product)
);

// File: rtl/vedic_mult8.sv
module vedic_mult8
    import vmul_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [PROD_W-1:0] product
);
    nib_pair_t         a_n, b_n;
    logic [CORE_W-1:0] core_p [NCORES];
    core_set_t         cores;
    logic [PROD_W-1:0] prod_c;

    assign a_n = split_op(op_a);
    assign b_n = split_op(op_b);

    // Slot index bit 1 selects the a nibble, bit 0 selects the b nibble (1 = high)
    generate
        for (genvar g = 0; g < NCORES; g++) begin : g_core
            localparam bit A_HI = g[1];
            localparam bit B_HI = g[0];
            vm_crosswise_core u_core (
                .x(A_HI ? a_n.hi : a_n.lo),
                .y(B_HI ? b_n.hi : b_n.lo),
                .p(core_p[g])
            );
        end
    endgenerate

    assign cores.ll = core_p[0];
    assign cores.lh = core_p[1];
    assign cores.hl = core_p[2];
    assign cores.hh = core_p[3];

    vm_overlap_merge u_merge (
        .cores(cores),
        .prod (prod_c)
    );

    generate
        if (REG_OUT) begin : g_out_reg
            logic [PROD_W-1:0] prod_q;
            always_ff @(posedge clk) begin
                if (rst) prod_q <= '0;
                else     prod_q <= prod_c;
            end
            assign product = prod_q;
        end else begin : g_out_comb
            assign product = prod_c;
        end
    endgenerate
endmodule

// File: tb/tb_vedic_mult8.sv
`timescale 1ns/1ps
module tb_vedic_mult8;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic [15:0] product;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    vedic_mult8 dut (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .product(product));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d actual=%h expected=%h", tag, op_a, op_b, act, exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_v;
        logic [15:0] held;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 reset", product, 16'h0000);
        rst = 1'b0;
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                op_a = 8'(a);
                op_b = 8'(b);
                @(posedge clk);
                #1;
                exp_v = 16'(a * b);
                chk("R1", product, exp_v);
                chk("R4", {12'h000, product[3:0]}, {12'h000, 4'((a % 16) * (b % 16))});
                if (a < 16 && b < 16)
                    chk("R2", product, 16'((a % 16) * (b % 16)));
                if (a % 16 == 0 && b % 16 == 0)
                    chk("R3", product, {8'((a / 16) * (b / 16)), 8'h00});
                if (a == 0 || b == 0)
                    chk("R5", product, 16'h0000);
                if (b == 1)
                    chk("R6", product, 16'(a));
                if (a == 1)
                    chk("R6", product, 16'(b));
                if (a == 255 && b == 255)
                    chk("R7", product, 16'hFE01);
            end
        end
        // Latency: new operands must not show before the next edge
        op_a = 8'd200; op_b = 8'd201;
        @(posedge clk); #1;
        held = product;
        chk("R8 load", held, 16'd40200);
        op_a = 8'd3; op_b = 8'd7;
        #1;
        chk("R8 hold", product, held);
        @(posedge clk); #1;
        chk("R8 latency", product, 16'd21);
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R8 midrun reset", product, 16'h0000);
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R8 after reset", product, 16'd21);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule